// File: doc/BRIEF.md
# Multiplexed LCD Row Scan Sequencer

This block decides which common row of a multiplexed liquid-crystal panel is driven at any moment. Software picks one of four row counts (8, 16, 20 or 24) with a two-bit mode field and can append one extra row for icon segments. The block then steps a row index once per row period and wraps at the end of each frame. On every wrap it emits a one-cycle frame strobe and flips a drive-polarity bit, so that consecutive frames are driven with opposite sign. The scan can run upward or downward.

The row period comes from one of two sources. The first is an internal oscillator tick, given as a clock-enable pulse from a divider. The second is the rising edge of a frame pin that is used as an input. When the internal source is chosen, the tick is echoed on that pin and the pin's output enable is raised. A sleep input halts stepping. A build-time option makes a completed initialisation word put the scan back on row 1, so that several such blocks stay aligned.

The sequencer state machine has two states. ST_RUN is the scanning state. ST_SLEEP holds the row index. ST_RUN goes to ST_SLEEP when sleep is sampled high, and ST_SLEEP goes back to ST_RUN when sleep is sampled low. Row index value k stands for panel row k+1.

Top module: `lcd_row_sequencer`

## Requirements
- R1: `mode_sel` selects the row count n: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 20 and 2'b11 gives 24. The index runs over 0..n-1, and every frame contains exactly n steps.
- R2: With `icon_en` high, the row count is the mode's count plus one (9, 17, 21 or 25).
- R3: With `reverse_scan` low, each step raises the index by one. From n-1 the index wraps to 0.
- R4: With `reverse_scan` high, each step lowers the index by one. From 0 the index wraps to n-1.
- R5: At a wrap, `frame_start` is high for exactly the next cycle and `polarity` inverts. At any other time `frame_start` stays low and `polarity` keeps its value.
- R6: When `col_only`=1 and `ext_frame_sel`=0, a row step happens on each `osc_tick` pulse. In that case `fr_oe` is 1 and `fr_out` is high in the cycle after each tick. In all other combinations `fr_oe` is 0, `osc_tick` has no effect, and one step happens per rising edge of `fr_in`, however long `fr_in` stays high.
- R7: While `sleep` is high, and in the first cycle after it falls, no step happens. Stepping resumes after that cycle.
- R8: With RESYNC_ON_INIT=1, an `init_done` pulse sets the index to 0 (row 1) on the next cycle, even if a step arrives in the same cycle. No frame strobe is issued.
- R9: A change of `mode_sel` or `icon_en` moves the index to the first row of the scan order: 0 for forward scan, n-1 for reverse scan. This takes priority over a step in the same cycle. The index never exceeds n-1 under a stable configuration.
- R10: After reset the index is 0, `polarity` is 0, and `frame_start` and `fr_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Row-count mode select |
| icon_en | input | 1 | Adds one icon row |
| reverse_scan | input | 1 | Downward scan order |
| col_only | input | 1 | Timebase select, first term |
| ext_frame_sel | input | 1 | Forces the external frame source when high |
| osc_tick | input | 1 | Internal divider tick (clock enable) |
| fr_in | input | 1 | External frame pin level |
| init_done | input | 1 | Pulse: initialisation word completed |
| sleep | input | 1 | Halts stepping |
| row_idx | output | ROW_W | Active row index (row k+1 shown as k) |
| frame_start | output | 1 | One-cycle strobe after a wrap |
| polarity | output | 1 | Frame drive polarity |
| fr_out | output | 1 | Echoed internal tick for the frame pin |
| fr_oe | output | 1 | Frame pin output enable |

## Verification
A row step can land in the same cycle as either a resynchronising initialisation pulse or a configuration change. The bench provokes both cases. It raises `init_done` together with `osc_tick`, and separately changes `mode_sel` together with `osc_tick`. It then checks that the index lands on row 1 or on the new first row, with no frame strobe and no polarity change. It also puts a tick in the cycle where sleep is released and checks that this tick is dropped.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MUX_A = 2'b00,
        MUX_B = 2'b01,
        MUX_C = 2'b10,
        MUX_D = 2'b11
    } mux_mode_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } seq_state_e;

endpackage

// File: rtl/lcd_row_limit.sv
module lcd_row_limit #(
    parameter int ROW_W  = 5,
    parameter int ROWS_A = 8,
    parameter int ROWS_B = 16,
    parameter int ROWS_C = 20,
    parameter int ROWS_D = 24
) (
    input  logic [1:0]       mode_sel,
    input  logic             icon_en,
    output logic [ROW_W-1:0] last_row
);
    import lcd_seq_pkg::*;

    logic [ROW_W-1:0] base_cnt;
    logic [ROW_W-1:0] icon_add;

    assign icon_add = {{(ROW_W-1){1'b0}}, icon_en};

    always_comb begin
        unique case (mux_mode_e'(mode_sel))
            MUX_A: base_cnt = ROW_W'(ROWS_A);
            MUX_B: base_cnt = ROW_W'(ROWS_B);
            MUX_C: base_cnt = ROW_W'(ROWS_C);
            MUX_D: base_cnt = ROW_W'(ROWS_D);
            default: base_cnt = ROW_W'(ROWS_A);
        endcase
        last_row = base_cnt + icon_add - ROW_W'(1);
    end

endmodule

// File: rtl/lcd_timebase.sv
module lcd_timebase (
    input  logic clk,
    input  logic rst_n,
    input  logic col_only,
    input  logic ext_frame_sel,
    input  logic osc_tick,
    input  logic fr_in,
    input  logic sleep,
    output logic step,
    output logic fr_out,
    output logic fr_oe
);
    logic use_internal;
    logic fr_q;
    logic ext_edge;

    assign use_internal = col_only & ~ext_frame_sel;
    assign ext_edge     = fr_in & ~fr_q;
    assign step         = use_internal ? osc_tick : ext_edge;
    assign fr_oe        = use_internal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q   <= 1'b0;
            fr_out <= 1'b0;
        end else begin
            fr_q   <= fr_in;
            fr_out <= use_internal & osc_tick & ~sleep;
        end
    end

    // R6
    fr_out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fr_out |-> ($past(osc_tick) && !$past(sleep)));

    // R6
    ext_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_internal && $past(fr_in) && fr_in) |-> !step);

endmodule

// File: rtl/lcd_row_counter.sv
module lcd_row_counter #(
    parameter int ROW_W          = 5,
    parameter bit RESYNC_ON_INIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] last_row,
    input  logic [1:0]       mode_sel,
    input  logic             icon_en,
    input  logic             reverse_scan,
    input  logic             step,
    input  logic             sleep,
    input  logic             init_done,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_start,
    output logic             polarity
);
    import lcd_seq_pkg::*;

    seq_state_e       state, state_nx;
    logic [2:0]       cfg_q;
    logic             cfg_chg;
    logic             resync;
    logic             adv;
    logic             wrap;
    logic [ROW_W-1:0] first_row;
    logic [ROW_W-1:0] row_nx;

    generate
        if (RESYNC_ON_INIT) begin : g_resync
            assign resync = init_done;
        end else begin : g_noresync
            assign resync = 1'b0;
        end
    endgenerate

    assign cfg_chg   = ({mode_sel, icon_en} != cfg_q);
    assign first_row = reverse_scan ? last_row : '0;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        adv      = 1'b0;
        unique case (state)
            ST_RUN: begin
                adv = step & ~sleep;
                if (sleep) state_nx = ST_SLEEP;
            end
            ST_SLEEP: begin
                adv = 1'b0;
                if (!sleep) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        row_nx = row_idx;
        wrap   = 1'b0;
        if (resync) begin
            row_nx = '0;
        end else if (cfg_chg) begin
            row_nx = first_row;
        end else if (adv) begin
            if (reverse_scan) begin
                if (row_idx == '0) begin
                    row_nx = last_row;
                    wrap   = 1'b1;
                end else begin
                    row_nx = row_idx - ROW_W'(1);
                end
            end else begin
                if (row_idx >= last_row) begin
                    row_nx = '0;
                    wrap   = 1'b1;
                end else begin
                    row_nx = row_idx + ROW_W'(1);
                end
            end
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_idx     <= '0;
            frame_start <= 1'b0;
            polarity    <= 1'b0;
            cfg_q       <= 3'b000;
        end else begin
            row_idx     <= row_nx;
            frame_start <= wrap;
            polarity    <= polarity ^ wrap;
            cfg_q       <= {mode_sel, icon_en};
        end
    end

    // R1
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_chg |-> (row_idx <= last_row));

    // R3
    fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reverse_scan && !resync && !cfg_chg && row_idx < last_row)
        |=> (row_idx == $past(row_idx) + ROW_W'(1)));

    // R5
    frame_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (polarity != $past(polarity)));

    // R7
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !resync && !cfg_chg) |=> $stable(row_idx));

    // R8
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (row_idx == '0 && !frame_start));

    // R9
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && !resync) |=> (row_idx == $past(first_row)));

endmodule

// File: rtl/lcd_row_sequencer.sv
module lcd_row_sequencer #(
    parameter int ROW_W          = 5,
    parameter int ROWS_A         = 8,
    parameter int ROWS_B         = 16,
    parameter int ROWS_C         = 20,
    parameter int ROWS_D         = 24,
    parameter bit RESYNC_ON_INIT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             icon_en,
    input  logic             reverse_scan,
    input  logic             col_only,
    input  logic             ext_frame_sel,
    input  logic             osc_tick,
    input  logic             fr_in,
    input  logic             init_done,
    input  logic             sleep,
    output logic [ROW_W-1:0] row_idx,
    output logic             frame_start,
    output logic             polarity,
    output logic             fr_out,
    output logic             fr_oe
);
    logic [ROW_W-1:0] last_row;
    logic             step;

    lcd_row_limit #(
        .ROW_W (ROW_W),
        .ROWS_A(ROWS_A),
        .ROWS_B(ROWS_B),
        .ROWS_C(ROWS_C),
        .ROWS_D(ROWS_D)
    ) u_limit (
        .mode_sel(mode_sel),
        .icon_en (icon_en),
        .last_row(last_row)
    );

    lcd_timebase u_tb (
        .clk          (clk),
        .rst_n        (rst_n),
        .col_only     (col_only),
        .ext_frame_sel(ext_frame_sel),
        .osc_tick     (osc_tick),
        .fr_in        (fr_in),
        .sleep        (sleep),
        .step         (step),
        .fr_out       (fr_out),
        .fr_oe        (fr_oe)
    );

    lcd_row_counter #(
        .ROW_W         (ROW_W),
        .RESYNC_ON_INIT(RESYNC_ON_INIT)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_row    (last_row),
        .mode_sel    (mode_sel),
        .icon_en     (icon_en),
        .reverse_scan(reverse_scan),
        .step        (step),
        .sleep       (sleep),
        .init_done   (init_done),
        .row_idx     (row_idx),
        .frame_start (frame_start),
        .polarity    (polarity)
    );

endmodule

// File: tb/sim_lcd_row_sequencer.sv
module sim_lcd_row_sequencer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic       icon_en, reverse_scan, col_only, ext_frame_sel;
    logic       osc_tick, fr_in, init_done, sleep;
    logic [4:0] row_idx;
    logic       frame_start, polarity, fr_out, fr_oe;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;
    logic [4:0] exp_row;
    logic       exp_pol;

    always #10 clk = ~clk;

    lcd_row_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .icon_en(icon_en),
        .reverse_scan(reverse_scan), .col_only(col_only),
        .ext_frame_sel(ext_frame_sel), .osc_tick(osc_tick), .fr_in(fr_in),
        .init_done(init_done), .sleep(sleep), .row_idx(row_idx),
        .frame_start(frame_start), .polarity(polarity), .fr_out(fr_out),
        .fr_oe(fr_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag, input logic fs_e);
        check({tag, " row"}, int'(row_idx), int'(exp_row));
        check({tag, " frame_start"}, int'(frame_start), int'(fs_e));
        check({tag, " polarity"}, int'(polarity), int'(exp_pol));
    endtask

    task automatic tick();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
    endtask

    function automatic int last_of(input int m, input int ic);
        return ((m == 0) ? 8 : 12 + 4 * m) + ic - 1;
    endfunction

    task automatic model_step(input bit rev, input int last, output bit wrapped);
        wrapped = 1'b0;
        if (!rev) begin
            if (int'(exp_row) == last) begin exp_row = '0; wrapped = 1'b1; end
            else exp_row = exp_row + 5'd1;
        end else begin
            if (exp_row == '0) begin exp_row = 5'(last); wrapped = 1'b1; end
            else exp_row = exp_row - 5'd1;
        end
        if (wrapped) exp_pol = ~exp_pol;
    endtask

    initial begin
        int pm, pi, last, seen;
        bit w;
        rst_n = 1'b0; mode_sel = 2'b00; icon_en = 1'b0; reverse_scan = 1'b0;
        col_only = 1'b1; ext_frame_sel = 1'b0; osc_tick = 1'b0; fr_in = 1'b0;
        init_done = 1'b0; sleep = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_row = '0; exp_pol = 1'b0;
        // R10 reset state
        check_state("R10 reset", 1'b0);
        check("R10 fr_out after reset", int'(fr_out), 0);
        check("R6 fr_oe internal", int'(fr_oe), 1);

        pm = 0; pi = 0; last = 7;
        for (int rev = 0; rev < 2; rev++) begin
            for (int m = 0; m < 4; m++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    last = last_of(m, ic);
                    @(negedge clk);
                    mode_sel = 2'(m); icon_en = ic[0]; reverse_scan = rev[0];
                    @(negedge clk);
                    if (m != pm || ic != pi) exp_row = rev[0] ? 5'(last) : 5'd0;
                    // R9 clamp to first row of scan order
                    check_state("R9 clamp", 1'b0);
                    pm = m; pi = ic; seen = 0;
                    for (int k = 0; k < 2 * (last + 1); k++) begin
                        tick();
                        model_step(rev[0], last, w);
                        if (frame_start) seen++;
                        // R3 forward, R4 reverse, R5 strobe/polarity
                        check_state(rev[0] ? "R4/R5 reverse" : "R3/R5 forward", w);
                    end
                    // R1 / R2 frame length
                    check(ic ? "R2 icon row count" : "R1 mode row count", seen, 2);
                end
            end
        end

        // sleep (reverse, 25 rows)
        last = 24;
        @(negedge clk) sleep = 1'b1;
        tick();
        check_state("R7 sleep hold", 1'b0);
        @(negedge clk) begin sleep = 1'b0; osc_tick = 1'b1; end
        @(negedge clk) osc_tick = 1'b0;
        check_state("R7 release cycle dropped", 1'b0);
        tick();
        model_step(1'b1, last, w);
        check_state("R7 resume", w);
        check("R6 fr_out echo", int'(fr_out), 1);
        @(negedge clk);
        check("R6 fr_out single", int'(fr_out), 0);

        // resync and step in the same cycle
        @(negedge clk) begin init_done = 1'b1; osc_tick = 1'b1; end
        @(negedge clk) begin init_done = 1'b0; osc_tick = 1'b0; end
        exp_row = '0;
        check_state("R8 resync beats step", 1'b0);

        // configuration change and step in the same cycle
        @(negedge clk) begin mode_sel = 2'b01; icon_en = 1'b0; osc_tick = 1'b1; end
        @(negedge clk) osc_tick = 1'b0;
        last = 15; exp_row = 5'd15;
        check_state("R9 clamp beats step", 1'b0);

        @(negedge clk) reverse_scan = 1'b0;
        tick();
        model_step(1'b0, last, w);
        check_state("R3 forward wrap", w);

        // external timebase through col_only=0
        @(negedge clk) col_only = 1'b0;
        @(negedge clk);
        check("R6 fr_oe external", int'(fr_oe), 0);
        tick();
        check_state("R6 tick ignored", 1'b0);
        @(negedge clk) fr_in = 1'b1;
        repeat (3) @(negedge clk);
        fr_in = 1'b0;
        model_step(1'b0, last, w);
        check_state("R6 one step per edge", w);

        // external timebase through ext_frame_sel=1
        @(negedge clk) begin col_only = 1'b1; ext_frame_sel = 1'b1; end
        @(negedge clk);
        check("R6 fr_oe forced external", int'(fr_oe), 0);
        @(negedge clk) fr_in = 1'b1;
        @(negedge clk) fr_in = 1'b0;
        model_step(1'b0, last, w);
        check_state("R6 ext frame select", w);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule